// File: doc/BRIEF.md
# Double-Buffered Serial Frame Transmitter

This block turns bytes written from a processor-style port into asynchronous serial frames on one output line. A holding register receives each byte. A separate shift register serializes the frame. Because the two are separate, software can load the next byte while the current frame is still going out. Back-to-back frames then leave no idle gap between them.

Each frame has the following parts, in order:
- a low start bit;
- 5 to 8 data bits, least significant first;
- an optional even or odd parity bit;
- one or two high stop bits.

The line advances one bit on each pulse of an external baud tick. The block exposes two flags: one says the holding register is empty, the other says the shifter is idle. Together they let the writer pace itself. The frame settings are captured when a byte moves into the shifter, so a change made mid-frame only affects later frames.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1 and `shift_empty` is 1.
- R2: A `wr_en` pulse while `hold_empty` is 1 stores `wr_data`, and `hold_empty` reads 0 from the next cycle.
- R3: A `wr_en` pulse while `hold_empty` is 0 is ignored. The held byte is unchanged and the ignored byte is never transmitted.
- R4: On a cycle with `baud_tick` high, a held byte, and an idle shifter (or a shifter finishing its last stop bit), the byte moves to the shifter. From the next cycle `hold_empty` is 1, `shift_empty` is 0 and `txd` is 0 (the start bit).
- R5: The start bit is followed by the data bits, least significant first. The count is set by `cfg_len`: 2'b00=5, 2'b01=6, 2'b10=7, 2'b11=8 bits.
- R6: When `cfg_par_en` is 1, a parity bit follows the data. It is computed over the active data bits only. With `cfg_par_odd`=0 the data bits plus parity hold an even number of ones; with `cfg_par_odd`=1 they hold an odd number.
- R7: The frame ends with one high stop bit, or two when `cfg_two_stop` is 1.
- R8: Every bit of the frame lasts from one `baud_tick` pulse to the next.
- R9: If a byte is held when the last stop bit ends, its start bit follows immediately, with no idle bit.
- R10: `cfg_len`, `cfg_par_en`, `cfg_par_odd` and `cfg_two_stop` are sampled at the transfer of R4. Changes during a frame do not alter that frame.
- R11: When the last stop bit ends with nothing held, `shift_empty` returns to 1. `txd` is 1 whenever `shift_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe into the holding register |
| wr_data | input | 8 | Byte to send |
| cfg_len | input | 2 | Data length select (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register can accept a byte |
| shift_empty | output | 1 | Shifter idle, no frame in progress |

## Verification
The bench sends single frames at all four data lengths. These are mixed with no parity, even parity and odd parity, and with one or two stop bits. The bytes are chosen so that bits above the active length would flip parity or leak onto the line if they were counted. A second byte written during a frame, followed by a third write that must be dropped, separates three cases: correct chaining with no gap, loss of the held byte, and overwrite by the dropped byte. Changing every setting in the middle of a frame shows whether the settings are latched at transfer or read live.

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_two_stop,
  output logic          txd,
  output logic          hold_empty,
  output logic          shift_empty
);
  localparam int PW = $clog2(DW + 5);
  localparam int IW = $clog2(DW);

  logic [DW-1:0] hold_q, sh_q;
  logic          hold_full, busy;
  logic [PW-1:0] pos, last_q, nbits_q;
  logic          par_en_q, par_q;

  logic [PW-1:0] nbits;
  logic [DW-1:0] mask;
  logic          frame_end, xfer, bit_out;

  assign nbits     = PW'(cfg_len) + PW'(5);
  assign mask      = {DW{1'b1}} >> (PW'(DW) - nbits);
  assign frame_end = busy && baud_tick && (pos == last_q);
  assign xfer      = baud_tick && hold_full && (!busy || frame_end);

  always_comb begin
    if (pos == '0)
      bit_out = 1'b0;
    else if (pos <= nbits_q)
      bit_out = sh_q[IW'(pos - PW'(1))];
    else if (par_en_q && pos == nbits_q + PW'(1))
      bit_out = par_q;
    else
      bit_out = 1'b1;
  end

  assign txd         = busy ? bit_out : 1'b1;
  assign hold_empty  = !hold_full;
  assign shift_empty = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (xfer) begin
      hold_full <= 1'b0;
    end else if (wr_en && !hold_full) begin
      hold_full <= 1'b1;
      hold_q    <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pos      <= '0;
      sh_q     <= '0;
      nbits_q  <= '0;
      last_q   <= '0;
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
    end else if (xfer) begin
      busy     <= 1'b1;
      pos      <= '0;
      sh_q     <= hold_q;
      nbits_q  <= nbits;
      last_q   <= nbits + PW'(cfg_par_en) + PW'(cfg_two_stop) + PW'(1);
      par_en_q <= cfg_par_en;
      par_q    <= (^(hold_q & mask)) ^ cfg_par_odd;
    end else if (frame_end) begin
      busy <= 1'b0;
    end else if (busy && baud_tick) begin
      pos <= pos + PW'(1);
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (txd && hold_empty && shift_empty));

  a_r11_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> txd);

  a_r4_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && !hold_empty && shift_empty) |=> (hold_empty && !shift_empty && !txd));

  a_r3_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_empty && !baud_tick) |=> (!hold_empty && $stable(hold_q)));

  a_r8_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !shift_empty) |=> $stable(txd));

  a_r7_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_empty) |-> $past(txd));
endmodule

// File: tb/uart_tx_dbuf_bench.sv
module uart_tx_dbuf_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       txd, hold_empty, shift_empty;

  int n_cmp = 0;
  int n_bad = 0;
  logic [255:0] exp_s;
  int           exp_n;

  uart_tx_dbuf u_uart_tx_dbuf (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      repeat (7) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic clear_exp();
    exp_s = '0;
    exp_n = 0;
  endtask

  task automatic add_bit(input logic b);
    exp_s[exp_n] = b;
    exp_n++;
  endtask

  task automatic add_frame(input logic [7:0] d, input logic [1:0] len,
                           input logic pe, input logic po, input logic ts);
    int   n = int'(len) + 5;
    logic p = po;
    add_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      add_bit(d[i]);
      p ^= d[i];
    end
    if (pe) add_bit(p);
    add_bit(1'b1);
    if (ts) add_bit(1'b1);
  endtask

  task automatic set_cfg(input logic [1:0] len, input logic pe, input logic po, input logic ts);
    @(negedge clk);
    cfg_len = len; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(posedge baud_tick);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic capture(input string req, input bit chk_flags);
    logic [255:0] got = '0;
    int           t = 0;
    while (txd !== 1'b0 && t < 400) begin
      @(negedge clk);
      t++;
    end
    if (chk_flags) begin
      check("R4 hold_empty after transfer", 256'(hold_empty), 256'(1));
      check("R4 shift_empty after transfer", 256'(shift_empty), 256'(0));
    end
    repeat (4) @(negedge clk);
    for (int i = 0; i < exp_n; i++) begin
      got[i] = txd;
      repeat (8) @(negedge clk);
    end
    check(req, got, exp_s);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 txd at reset", 256'(txd), 256'(1));
    check("R1 hold_empty at reset", 256'(hold_empty), 256'(1));
    check("R1 shift_empty at reset", 256'(shift_empty), 256'(1));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_single(input string req, input logic [7:0] d, input logic [1:0] len,
                          input logic pe, input logic po, input logic ts);
    set_cfg(len, pe, po, ts);
    clear_exp();
    add_frame(d, len, pe, po, ts);
    add_bit(1'b1);
    add_bit(1'b1);
    write_byte(d);
    check("R2 hold_empty low after write", 256'(hold_empty), 256'(0));
    capture(req, 1'b1);
    check("R11 shift_empty after frame", 256'(shift_empty), 256'(1));
    check("R11 hold_empty after frame", 256'(hold_empty), 256'(1));
  endtask

  task automatic t_chain();
    set_cfg(2'b11, 1'b1, 1'b0, 1'b0);
    clear_exp();
    add_frame(8'h3C, 2'b11, 1'b1, 1'b0, 1'b0);
    add_frame(8'hC1, 2'b11, 1'b1, 1'b0, 1'b0);
    add_bit(1'b1);
    add_bit(1'b1);
    fork
      capture("R9 R3 chained frames, dropped write absent", 1'b0);
      begin
        write_byte(8'h3C);
        write_byte(8'hC1);
        check("R2 second byte held", 256'(hold_empty), 256'(0));
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 hold stays full on ignored write", 256'(hold_empty), 256'(0));
      end
    join
    check("R11 idle after chain", 256'(shift_empty), 256'(1));
  endtask

  task automatic t_latch();
    set_cfg(2'b01, 1'b1, 1'b1, 1'b1);
    clear_exp();
    add_frame(8'hD6, 2'b01, 1'b1, 1'b1, 1'b1);
    add_bit(1'b1);
    fork
      capture("R10 settings latched at transfer", 1'b0);
      begin
        write_byte(8'hD6);
        repeat (20) @(negedge clk);
        cfg_len = 2'b11; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
      end
    join
  endtask

  initial begin
    #4000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single("R5 R8 8 bits no parity 1 stop", 8'hA5, 2'b11, 1'b0, 1'b0, 1'b0);
    t_single("R5 R6 R7 5 bits even parity 2 stop", 8'hF3, 2'b00, 1'b1, 1'b0, 1'b1);
    t_single("R5 R6 7 bits odd parity", 8'hB5, 2'b10, 1'b1, 1'b1, 1'b0);
    t_single("R5 R7 6 bits no parity 2 stop", 8'hED, 2'b01, 1'b0, 1'b0, 1'b1);
    t_single("R6 8 bits odd parity", 8'h00, 2'b11, 1'b1, 1'b1, 1'b0);
    t_chain();
    t_latch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule